// File: doc/BRIEF.md
# Integer Interval Arithmetic Unit

This unit does arithmetic on closed integer intervals. Each operand is a pair of signed two's-complement endpoints, low and high. An opcode selects one of four operations: add, subtract, multiply or divide. The unit returns the bounding interval of the result as a low/high pair. Multiply and divide form all four cross-combinations of the operand endpoints and keep the smallest and the largest. Subtract pairs each endpoint of the minuend with the opposite endpoint of the subtrahend.

The unit is a single registered stage. An operation presented with `in_valid` high is sampled on a rising clock edge. Its result appears on the outputs after that edge, with `out_valid` high, and a new operation can be accepted on every cycle. The result endpoints are 2W+1 bits wide, so no operation can wrap around. Three flags come with each result:
- a divisor interval that contains zero, in which case the result is forced to [0,0];
- an operand whose low endpoint exceeds its high endpoint (malformed);
- a result whose two endpoints are equal (degenerate).

Top module: `ival_arith`

## Requirements
- R1: With opcode 2'b00 (add), the result is [a_lo+b_lo, a_hi+b_hi].
- R2: With opcode 2'b01 (subtract), the result is [a_lo-b_hi, a_hi-b_lo].
- R3: With opcode 2'b10 (multiply), the result low and high are the minimum and maximum of the four products a_lo*b_lo, a_lo*b_hi, a_hi*b_lo and a_hi*b_hi.
- R4: With opcode 2'b11 (divide), the result low and high are the minimum and maximum of the four quotients of a_lo and a_hi by b_lo and b_hi, each quotient truncated toward zero.
- R5: For a divide whose divisor satisfies b_lo <= 0 <= b_hi, `bad_div` is 1 and the result is [0,0]. For any other operation, `bad_div` is 0.
- R6: `bad_order` is 1 when a_lo > a_hi or b_lo > b_hi, and 0 otherwise. The result endpoints are then unspecified.
- R7: `is_point` is 1 exactly when the delivered res_lo equals res_hi.
- R8: `out_valid` is 1 in the cycle after an edge that sampled `in_valid` high, and 0 otherwise, including after reset. While `out_valid` is 0, all three flags are 0.
- R9: The endpoints are 2W+1-bit signed values and never wrap, even at the extremes of the operand range (for example -2^(W-1) times -2^(W-1), and -2^(W-1) divided by -1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 divide |
| a_lo | input | W | First operand low endpoint (signed) |
| a_hi | input | W | First operand high endpoint (signed) |
| b_lo | input | W | Second operand low endpoint (signed) |
| b_hi | input | W | Second operand high endpoint (signed) |
| out_valid | output | 1 | Result present |
| res_lo | output | 2W+1 | Result low endpoint (signed) |
| res_hi | output | 2W+1 | Result high endpoint (signed) |
| bad_div | output | 1 | Divisor interval contains zero |
| bad_order | output | 1 | An operand has low > high |
| is_point | output | 1 | Result endpoints equal |

## Verification
The hardest case to reach is one where the winning endpoint combination changes with the operand signs. Mixed-sign multiplies and divides pick a different corner product or quotient than same-sign ones. The truncating quotient of the most negative value by -1 only fits because of the wider result. The stimulus therefore walks intervals that straddle zero, lie entirely below zero and sit at the range limits. It also places divisors that touch zero at exactly one endpoint. Idle gaps between back-to-back operations test that the flags clear when no result is present.

// File: rtl/ival_arith.sv
module ival_arith #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            op,
  input  logic signed [W-1:0]   a_lo,
  input  logic signed [W-1:0]   a_hi,
  input  logic signed [W-1:0]   b_lo,
  input  logic signed [W-1:0]   b_hi,
  output logic                  out_valid,
  output logic signed [2*W:0]   res_lo,
  output logic signed [2*W:0]   res_hi,
  output logic                  bad_div,
  output logic                  bad_order,
  output logic                  is_point
);
  localparam int RW = 2*W + 1;
  localparam logic [1:0] OP_ADD = 2'b00, OP_SUB = 2'b01, OP_MUL = 2'b10, OP_DIV = 2'b11;

  function automatic logic signed [RW-1:0] mn(input logic signed [RW-1:0] x, input logic signed [RW-1:0] y);
    return (x < y) ? x : y;
  endfunction

  function automatic logic signed [RW-1:0] mx(input logic signed [RW-1:0] x, input logic signed [RW-1:0] y);
    return (x > y) ? x : y;
  endfunction

  logic signed [RW-1:0] al, ah, bl, bh, bl_nz, bh_nz;
  logic signed [RW-1:0] p0, p1, p2, p3, q0, q1, q2, q3;
  logic signed [RW-1:0] nlo, nhi;
  logic                 spans_zero, order_err, div_err;

  assign al = {{(RW-W){a_lo[W-1]}}, a_lo};
  assign ah = {{(RW-W){a_hi[W-1]}}, a_hi};
  assign bl = {{(RW-W){b_lo[W-1]}}, b_lo};
  assign bh = {{(RW-W){b_hi[W-1]}}, b_hi};

  assign spans_zero = (b_lo <= 0) && (b_hi >= 0);
  assign order_err  = (a_lo > a_hi) || (b_lo > b_hi);
  assign div_err    = (op == OP_DIV) && spans_zero;

  assign p0 = al * bl;
  assign p1 = al * bh;
  assign p2 = ah * bl;
  assign p3 = ah * bh;

  assign bl_nz = (bl == 0) ? RW'(1) : bl;
  assign bh_nz = (bh == 0) ? RW'(1) : bh;
  assign q0 = al / bl_nz;
  assign q1 = al / bh_nz;
  assign q2 = ah / bl_nz;
  assign q3 = ah / bh_nz;

  always_comb begin
    case (op)
      OP_ADD: begin nlo = al + bl; nhi = ah + bh; end
      OP_SUB: begin nlo = al - bh; nhi = ah - bl; end
      OP_MUL: begin nlo = mn(mn(p0, p1), mn(p2, p3)); nhi = mx(mx(p0, p1), mx(p2, p3)); end
      default: begin
        if (div_err) begin
          nlo = '0; nhi = '0;
        end else begin
          nlo = mn(mn(q0, q1), mn(q2, q3)); nhi = mx(mx(q0, q1), mx(q2, q3));
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
      bad_div   <= 1'b0;
      bad_order <= 1'b0;
      is_point  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      res_lo    <= in_valid ? nlo : '0;
      res_hi    <= in_valid ? nhi : '0;
      bad_div   <= in_valid && div_err;
      bad_order <= in_valid && order_err;
      is_point  <= in_valid && (nlo == nhi);
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !bad_div && !bad_order && !is_point);
  // R5
  div_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_div |-> res_lo == 0 && res_hi == 0);
  // R5
  div_flag_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != OP_DIV |=> !bad_div);
  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_ADD |=> res_lo == $past(al) + $past(bl) && res_hi == $past(ah) + $past(bh));
  // R3
  ordered_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !bad_order |-> res_lo <= res_hi);
endmodule

// File: tb/sim_ival_arith.sv
module sim_ival_arith;
  localparam int W = 8;
  localparam int RW = 2*W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic signed [W-1:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
  logic out_valid, bad_div, bad_order, is_point;
  logic signed [RW-1:0] res_lo, res_hi;

  always #10 clk = ~clk;

  ival_arith #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
    .bad_div(bad_div), .bad_order(bad_order), .is_point(is_point));

  typedef struct {
    longint lo;
    longint hi;
    bit     bd;
    bit     bo;
    bit     pt;
    string  req;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lmin(input longint x, input longint y);
    return (x < y) ? x : y;
  endfunction
  function automatic longint lmax(input longint x, input longint y);
    return (x > y) ? x : y;
  endfunction

  task automatic send(input logic [1:0] o, input int al, input int ah, input int bl, input int bh, input string req);
    exp_t e;
    longint x0, x1, x2, x3;
    e.req = req;
    e.bo = (al > ah) || (bl > bh);
    e.bd = (o == 2'b11) && (bl <= 0) && (bh >= 0);
    case (o)
      2'b00: begin e.lo = al + bl; e.hi = ah + bh; end
      2'b01: begin e.lo = al - bh; e.hi = ah - bl; end
      2'b10: begin
        x0 = longint'(al) * bl; x1 = longint'(al) * bh;
        x2 = longint'(ah) * bl; x3 = longint'(ah) * bh;
        e.lo = lmin(lmin(x0, x1), lmin(x2, x3)); e.hi = lmax(lmax(x0, x1), lmax(x2, x3));
      end
      default: begin
        if (e.bd || bl == 0 || bh == 0) begin
          e.lo = 0; e.hi = 0;
        end else begin
          x0 = longint'(al) / bl; x1 = longint'(al) / bh;
          x2 = longint'(ah) / bl; x3 = longint'(ah) / bh;
          e.lo = lmin(lmin(x0, x1), lmin(x2, x3)); e.hi = lmax(lmax(x0, x1), lmax(x2, x3));
        end
      end
    endcase
    e.pt = (e.lo == e.hi);
    @(negedge clk);
    op = o; a_lo = W'(al); a_hi = W'(ah); b_lo = W'(bl); b_hi = W'(bh);
    in_valid = 1'b1;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(bad_order == e.bo, {e.req, " R6 bad_order"}, bad_order, e.bo);
          if (!e.bo) begin
            chk(longint'(res_lo) == e.lo, {e.req, " res_lo"}, res_lo, e.lo);
            chk(longint'(res_hi) == e.hi, {e.req, " res_hi"}, res_hi, e.hi);
            chk(bad_div == e.bd, {e.req, " R5 bad_div"}, bad_div, e.bd);
            chk(is_point == e.pt, {e.req, " R7 is_point"}, is_point, e.pt);
          end
        end
      end else begin
        chk(!bad_div && !bad_order && !is_point, "R8 flags while idle",
            {bad_div, bad_order, is_point}, 0);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    chk(res_lo == 0 && res_hi == 0, "R8 reset result", res_lo, 0);

    send(2'b00, 2, 4, 6, 8, "R1 add");
    send(2'b00, -5, 3, -7, -1, "R1 add mixed");
    send(2'b00, 127, 127, 127, 127, "R1 R9 add max");
    send(2'b01, 2, 4, 6, 8, "R2 sub");
    send(2'b01, -128, -128, 127, 127, "R2 R9 sub extreme");
    idle(2);
    send(2'b10, 3, 4, 5, 6, "R3 mul pos");
    send(2'b10, -3, 4, -5, 6, "R3 mul straddle");
    send(2'b10, -9, -2, 3, 7, "R3 mul negpos");
    send(2'b10, -128, 127, -128, 127, "R3 R9 mul extreme");
    send(2'b10, -128, -128, -128, -128, "R3 R9 mul corner");
    send(2'b11, 20, 40, 3, 7, "R4 div pos");
    send(2'b11, -7, 9, -4, -2, "R4 div trunc");
    send(2'b11, -128, -128, -1, -1, "R4 R9 div min by -1");
    send(2'b11, 5, 9, 0, 3, "R5 div zero at lo");
    send(2'b11, 5, 9, -3, 0, "R5 div zero at hi");
    send(2'b11, 5, 9, -3, 3, "R5 div straddle");
    send(2'b01, 5, 9, -3, 3, "R5 sub no flag");
    idle(1);
    send(2'b00, 4, 1, 0, 0, "R6 a reversed");
    send(2'b10, 1, 4, 3, -2, "R6 b reversed");
    send(2'b00, 3, 3, -3, -3, "R7 point");
    send(2'b10, 0, 5, 0, 0, "R7 mul by zero");
    idle(4);
    done = 1'b1;
    chk(sb.size() == 0, "R8 all results delivered", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule